// File: doc/BRIEF.md
# Iterative Virtual-Branch Target Sequencer

This block predicts where an indirect branch will go without a dedicated target table. It turns one indirect branch into a short chain of pretend conditional branches. Each link in the chain has its own address and history value. It sends each link to the fetch unit's existing branch target buffer and direction predictor. Those structures are outside the block and answer within the same cycle. The first link that both hits in the buffer and is predicted taken supplies the target. A buffer miss ends the chain early. So does running out of links. In either case the outcome is a stall, and the front end waits until the branch resolves.

The fetch unit presents a branch address and the global history captured at fetch. It does this while the block is idle. After that the block runs one lookup per clock. It finishes with a single-cycle result pulse. The pulse carries either a target or a stall, plus the number of links used. That count travels with the branch down the pipeline so that the branch can later be trained. A flush input abandons a chain in progress.

Top module: `vbr_target_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `lk_valid` and `done` are low.
- R2: A request (`req_valid` high while `busy` is low and `flush` is low) starts a chain. In the next cycle the first lookup presents `lk_vpc` equal to the request address and `lk_vhist` equal to the request history. A request made while busy has no effect on the chain in progress.
- R3: While busy, exactly one lookup is presented per cycle (`lk_valid` high). Lookups stay back to back until the chain ends.
- R4: If a lookup hits (`btb_hit`) and is predicted taken (`dir_taken`), then in the next cycle `done` pulses with `done_hit` high and `done_target` equal to the `btb_target` of that lookup.
- R5: If a lookup misses, then in the next cycle `done` pulses with `done_hit` low and `done_target` zero. No further lookup follows.
- R6: If lookup number MAX_ITER hits but is predicted not taken, the chain ends with a stall outcome, and `done_iter` equals MAX_ITER.
- R7: Lookup k, for k from 2 up, presents the branch address XOR a salt. The salt is the low ADDR_W bits of (k-1) × 0x9E3779B97F4A7C15, taken modulo 2^64.
- R8: After a hit that is predicted not taken and is not the last lookup, the next lookup's history is the previous one shifted left by one, with a zero entering at bit 0.
- R9: `done_iter` gives the 1-based number of the lookup that ended the chain.
- R10: When `flush` is high at a clock edge, the block is idle in the next cycle. No lookup is presented, no `done` pulse arrives for the abandoned chain, and a request made in that same cycle is dropped.
- R11: `done` lasts a single cycle, and `busy` is low whenever `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a prediction for a new indirect branch |
| req_pc | input | ADDR_W | Address of the indirect branch |
| req_ghr | input | HIST_W | Global history at fetch |
| flush | input | 1 | Abort any chain in progress |
| busy | output | 1 | Chain in progress; new requests are ignored |
| lk_valid | output | 1 | Lookup presented this cycle |
| lk_vpc | output | ADDR_W | Virtual address of this lookup |
| lk_vhist | output | HIST_W | Virtual history of this lookup |
| btb_hit | input | 1 | Target buffer hit for this lookup |
| btb_target | input | ADDR_W | Target stored for this lookup |
| dir_taken | input | 1 | Direction prediction for this lookup |
| done | output | 1 | One-cycle result pulse |
| done_hit | output | 1 | High when the result is a target; low for a stall |
| done_target | output | ADDR_W | Predicted target (zero on stall) |
| done_iter | output | $clog2(MAX_ITER+1) | Number of lookups used |

## Verification
The properties assume that the external predictor arrays answer in the same cycle. They also assume that `btb_hit`, `btb_target` and `dir_taken` are functions only of the current `lk_vpc` and `lk_vhist`, and that reset is held for at least one edge before operation. The bench models both arrays as lookup tables keyed by virtual address and by address plus history. It drives the response inputs combinationally from the presented lookup, so every response belongs to the lookup on the ports in that cycle. Stimulus changes only on the falling edge. Requests made while busy, and flushes, are placed deliberately so that each one lands on a known lookup.

// File: rtl/vbr_pkg.sv
// Package: shared types and the per-iteration salt generator for the
// virtual-branch target sequencer.
// Assumes address widths of at most 64 bits.
package vbr_pkg;

    // Decision taken for the lookup presented in the current cycle.
    typedef enum logic [1:0] {
        VB_CONT    = 2'd0,  // hit, not taken, more lookups allowed
        VB_HIT     = 2'd1,  // hit and taken: target found
        VB_MISS    = 2'd2,  // buffer miss: stall
        VB_EXHAUST = 2'd3   // hit, not taken, last lookup: stall
    } vbr_step_e;

    // Salt for lookup k is derived from j = k-1 by an odd multiplier,
    // which keeps every salt distinct for j below 2^64.
    function automatic logic [63:0] vbr_salt(input int unsigned j);
        return 64'(j) * 64'h9E37_79B9_7F4A_7C15;
    endfunction

endpackage

// File: rtl/vbr_salt_table.sv
// Module: vbr_salt_table
// Holds the fixed salt constants, one for each lookup after the first, and
// returns the salt for the lookup number given. Lookup 1 (or any number out
// of range) gets a zero salt, so the branch's own address is used unchanged.
// Assumes MAX_ITER >= 2 and ADDR_W <= 64.
module vbr_salt_table #(
    parameter int ADDR_W   = 32,
    parameter int MAX_ITER = 4,
    localparam int IW      = $clog2(MAX_ITER + 1),
    localparam int NSALT   = MAX_ITER - 1
) (
    input  logic [IW-1:0]     iter_idx,
    output logic [ADDR_W-1:0] salt
);

    logic [ADDR_W-1:0] tab [NSALT];

    // One hard-wired constant per later lookup, computed at elaboration.
    for (genvar j = 0; j < NSALT; j++) begin : g_salt
        localparam logic [63:0] FULL = vbr_pkg::vbr_salt(j + 1);
        assign tab[j] = FULL[ADDR_W-1:0];
    end

    // Pick the constant that belongs to the current lookup number.
    always_comb begin
        salt = '0;
        for (int j = 0; j < NSALT; j++) begin
            if (iter_idx == IW'(j + 2)) begin
                salt = tab[j];
            end
        end
    end

endmodule

// File: rtl/vbr_step_eval.sv
// Module: vbr_step_eval
// Combinational decision for one lookup. It classifies the same-cycle answer
// of the target buffer and direction predictor as a found target, a miss, an
// exhausted chain, or a request to continue. Assumes the answers belong to
// the lookup presented in this cycle.
module vbr_step_eval (
    input  logic              active,
    input  logic              btb_hit,
    input  logic              dir_taken,
    input  logic              last_iter,
    output vbr_pkg::vbr_step_e step
);
    import vbr_pkg::*;

    // A miss wins over any direction answer; taken needs a hit.
    always_comb begin
        if (!active) begin
            step = VB_CONT;
        end else if (!btb_hit) begin
            step = VB_MISS;
        end else if (dir_taken) begin
            step = VB_HIT;
        end else if (last_iter) begin
            step = VB_EXHAUST;
        end else begin
            step = VB_CONT;
        end
    end

endmodule

// File: rtl/vbr_iter_ctrl.sv
// Module: vbr_iter_ctrl
// Sequencing state. Captures a request when idle, then keeps the branch
// address, the virtual history and the lookup number. It advances one lookup
// per cycle and registers the final outcome as a one-cycle pulse. Flush has
// priority over every other event. Assumes HIST_W >= 2.
module vbr_iter_ctrl #(
    parameter int ADDR_W   = 32,
    parameter int HIST_W   = 16,
    parameter int MAX_ITER = 4,
    localparam int IW      = $clog2(MAX_ITER + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_pc,
    input  logic [HIST_W-1:0]  req_ghr,
    input  logic               flush,
    input  vbr_pkg::vbr_step_e step,
    input  logic [ADDR_W-1:0]  btb_target,
    output logic               busy_q,
    output logic [ADDR_W-1:0]  pc_q,
    output logic [HIST_W-1:0]  vhist_q,
    output logic [IW-1:0]      iter_q,
    output logic               last_iter,
    output logic               done_q,
    output logic               hit_q,
    output logic [ADDR_W-1:0]  tgt_q,
    output logic [IW-1:0]      done_iter_q
);
    import vbr_pkg::*;

    logic start;

    // Accept a request only when idle and not being flushed.
    assign start     = req_valid && !busy_q && !flush;
    // The current lookup is the final one allowed.
    assign last_iter = (iter_q == IW'(MAX_ITER));

    // Chain state: start, advance, finish or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q      <= 1'b0;
            pc_q        <= '0;
            vhist_q     <= '0;
            iter_q      <= '0;
            done_q      <= 1'b0;
            hit_q       <= 1'b0;
            tgt_q       <= '0;
            done_iter_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (flush) begin
                busy_q <= 1'b0;
            end else if (start) begin
                busy_q  <= 1'b1;
                pc_q    <= req_pc;
                vhist_q <= req_ghr;
                iter_q  <= IW'(1);
            end else if (busy_q) begin
                unique case (step)
                    VB_HIT: begin
                        busy_q      <= 1'b0;
                        done_q      <= 1'b1;
                        hit_q       <= 1'b1;
                        tgt_q       <= btb_target;
                        done_iter_q <= iter_q;
                    end
                    VB_MISS, VB_EXHAUST: begin
                        busy_q      <= 1'b0;
                        done_q      <= 1'b1;
                        hit_q       <= 1'b0;
                        tgt_q       <= '0;
                        done_iter_q <= iter_q;
                    end
                    default: begin
                        iter_q  <= iter_q + IW'(1);
                        vhist_q <= {vhist_q[HIST_W-2:0], 1'b0};
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/vbr_target_seq.sv
// Module: vbr_target_seq (top)
// Predicts an indirect branch target by walking a chain of virtual
// conditional branches through external target-buffer and direction
// ports, one lookup per cycle. Assumes the external ports answer
// combinationally for the lookup presented in the same cycle.
module vbr_target_seq #(
    parameter int ADDR_W   = 32,
    parameter int HIST_W   = 16,
    parameter int MAX_ITER = 4,
    localparam int IW      = $clog2(MAX_ITER + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_pc,
    input  logic [HIST_W-1:0] req_ghr,
    input  logic              flush,
    output logic              busy,
    output logic              lk_valid,
    output logic [ADDR_W-1:0] lk_vpc,
    output logic [HIST_W-1:0] lk_vhist,
    input  logic              btb_hit,
    input  logic [ADDR_W-1:0] btb_target,
    input  logic              dir_taken,
    output logic              done,
    output logic              done_hit,
    output logic [ADDR_W-1:0] done_target,
    output logic [IW-1:0]     done_iter
);
    import vbr_pkg::*;

    logic              busy_q;
    logic [ADDR_W-1:0] pc_q;
    logic [HIST_W-1:0] vhist_q;
    logic [IW-1:0]     iter_q;
    logic              last_iter;
    logic [ADDR_W-1:0] salt;
    vbr_step_e         step;

    vbr_iter_ctrl #(
        .ADDR_W  (ADDR_W),
        .HIST_W  (HIST_W),
        .MAX_ITER(MAX_ITER)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_pc     (req_pc),
        .req_ghr    (req_ghr),
        .flush      (flush),
        .step       (step),
        .btb_target (btb_target),
        .busy_q     (busy_q),
        .pc_q       (pc_q),
        .vhist_q    (vhist_q),
        .iter_q     (iter_q),
        .last_iter  (last_iter),
        .done_q     (done),
        .hit_q      (done_hit),
        .tgt_q      (done_target),
        .done_iter_q(done_iter)
    );

    vbr_salt_table #(
        .ADDR_W  (ADDR_W),
        .MAX_ITER(MAX_ITER)
    ) u_salt (
        .iter_idx(iter_q),
        .salt    (salt)
    );

    vbr_step_eval u_eval (
        .active   (busy_q),
        .btb_hit  (btb_hit),
        .dir_taken(dir_taken),
        .last_iter(last_iter),
        .step     (step)
    );

    // Present the current virtual branch on the lookup ports.
    assign busy     = busy_q;
    assign lk_valid = busy_q;
    assign lk_vpc   = pc_q ^ salt;
    assign lk_vhist = vhist_q;

endmodule

// File: rtl/vbr_target_seq_checker.sv
// Module: vbr_target_seq_checker
// Temporal properties of the sequencer, observed at its ports only.
// Assumes that the response inputs depend only on the lookup presented
// in the same cycle.
module vbr_target_seq_checker #(
    parameter int ADDR_W   = 32,
    parameter int HIST_W   = 16,
    parameter int MAX_ITER = 4,
    localparam int IW      = $clog2(MAX_ITER + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_pc,
    input logic [HIST_W-1:0] req_ghr,
    input logic              flush,
    input logic              busy,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_vpc,
    input logic [HIST_W-1:0] lk_vhist,
    input logic              btb_hit,
    input logic [ADDR_W-1:0] btb_target,
    input logic              dir_taken,
    input logic              done,
    input logic              done_hit,
    input logic [ADDR_W-1:0] done_target,
    input logic [IW-1:0]     done_iter
);

    assert_start_lookup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !flush) |=>
            (lk_valid && lk_vpc == $past(req_pc) && lk_vhist == $past(req_ghr)));

    assert_lookup_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && btb_hit && !dir_taken && !flush) |=> (lk_valid || done));

    assert_hit_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && btb_hit && dir_taken && !flush) |=>
            (done && done_hit && done_target == $past(btb_target)));

    assert_miss_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !btb_hit && !flush) |=>
            (done && !done_hit && done_target == '0 && !lk_valid));

    assert_iter_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_iter >= IW'(1) && done_iter <= IW'(MAX_ITER)));

    assert_hist_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && btb_hit && !dir_taken && !flush) |=>
            (!lk_valid || lk_vhist == {$past(lk_vhist[HIST_W-2:0]), 1'b0}));

    assert_flush_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!done && !lk_valid && !busy));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind vbr_target_seq vbr_target_seq_checker #(
    .ADDR_W  (ADDR_W),
    .HIST_W  (HIST_W),
    .MAX_ITER(MAX_ITER)
) u_vbr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_pc     (req_pc),
    .req_ghr    (req_ghr),
    .flush      (flush),
    .busy       (busy),
    .lk_valid   (lk_valid),
    .lk_vpc     (lk_vpc),
    .lk_vhist   (lk_vhist),
    .btb_hit    (btb_hit),
    .btb_target (btb_target),
    .dir_taken  (dir_taken),
    .done       (done),
    .done_hit   (done_hit),
    .done_target(done_target),
    .done_iter  (done_iter)
);

// File: tb/vbr_target_seq_bench.sv
// Bench: behavioural reference of the lookup chain. The target-buffer and
// direction tables are associative arrays; expected lookups are queued and
// compared on every clock.
module vbr_target_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int HW = 16;
    localparam int MI = 4;
    localparam int IW = $clog2(MI + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_pc = '0;
    logic [HW-1:0] req_ghr = '0;
    logic          flush = 1'b0;
    logic          busy, lk_valid, done, done_hit;
    logic [AW-1:0] lk_vpc, done_target;
    logic [HW-1:0] lk_vhist;
    logic          btb_hit, dir_taken;
    logic [AW-1:0] btb_target;
    logic [IW-1:0] done_iter;

    int checks = 0;
    int errors = 0;

    logic [AW-1:0] btb_tab [logic [AW-1:0]];
    bit            dir_tab [logic [AW+HW-1:0]];

    always #(CLK_PERIOD/2) clk = ~clk;

    vbr_target_seq #(.ADDR_W(AW), .HIST_W(HW), .MAX_ITER(MI)) u_vbr_target_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pc(req_pc),
        .req_ghr(req_ghr), .flush(flush), .busy(busy), .lk_valid(lk_valid),
        .lk_vpc(lk_vpc), .lk_vhist(lk_vhist), .btb_hit(btb_hit),
        .btb_target(btb_target), .dir_taken(dir_taken), .done(done),
        .done_hit(done_hit), .done_target(done_target), .done_iter(done_iter)
    );

    // Same-cycle model of the external predictor arrays.
    always_comb begin
        btb_hit    = lk_valid && btb_tab.exists(lk_vpc);
        btb_target = btb_hit ? btb_tab[lk_vpc] : '0;
        dir_taken  = lk_valid && dir_tab.exists({lk_vpc, lk_vhist});
    end

    function automatic logic [AW-1:0] salt_of(input int k);
        logic [63:0] p;
        if (k <= 1) return '0;
        p = 64'(k - 1) * 64'h9E3779B97F4A7C15;
        return p[AW-1:0];
    endfunction

    function automatic logic [AW-1:0] vaddr(input logic [AW-1:0] pc, input int k);
        return pc ^ salt_of(k);
    endfunction

    function automatic logic [HW-1:0] vhist(input logic [HW-1:0] g, input int k);
        return g << (k - 1);
    endfunction

    // Install lookup k of a branch in the tables.
    task automatic plant(input logic [AW-1:0] pc, input logic [HW-1:0] g,
                         input int k, input logic [AW-1:0] tgt, input bit taken);
        btb_tab[vaddr(pc, k)] = tgt;
        if (taken) dir_tab[{vaddr(pc, k), vhist(g, k)}] = 1'b1;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Run one branch through the chain and compare every cycle.
    task automatic run_case(input logic [AW-1:0] pc, input logic [HW-1:0] g,
                            input int flush_after, input bit poke_busy, input string req);
        logic [AW-1:0] qa[$];
        logic [HW-1:0] qh[$];
        bit            e_hit = 0;
        logic [AW-1:0] e_tgt = '0;
        int            e_iter = 0;
        int            n;
        for (int k = 1; k <= MI; k++) begin
            logic [AW-1:0] va;
            va = vaddr(pc, k);
            qa.push_back(va);
            qh.push_back(vhist(g, k));
            e_iter = k;
            if (!btb_tab.exists(va)) break;
            if (dir_tab.exists({va, vhist(g, k)})) begin
                e_hit = 1; e_tgt = btb_tab[va]; break;
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_pc = pc; req_ghr = g;
        @(negedge clk);
        req_valid = 1'b0;
        n = qa.size();
        for (int i = 0; i < n; i++) begin
            check(lk_valid === 1'b1, "R3", "lookup valid", 64'(lk_valid), 64'd1);
            check(lk_vpc === qa[i], (i == 0) ? "R2" : "R7", "lookup address",
                  64'(lk_vpc), 64'(qa[i]));
            check(lk_vhist === qh[i], (i == 0) ? "R2" : "R8", "lookup history",
                  64'(lk_vhist), 64'(qh[i]));
            check(done === 1'b0, "R11", "no done while busy", 64'(done), 64'd0);
            req_valid = 1'b0;
            if (poke_busy && i == 0) begin
                req_valid = 1'b1; req_pc = pc ^ 32'h00F0_0000; req_ghr = ~g;
            end
            if (flush_after == i + 1) begin
                flush = 1'b1;
                @(negedge clk);
                flush = 1'b0;
                check(busy === 1'b0 && lk_valid === 1'b0, "R10", "idle after flush",
                      64'({busy, lk_valid}), 64'd0);
                check(done === 1'b0, "R10", "no done after flush", 64'(done), 64'd0);
                @(negedge clk);
                check(done === 1'b0 && lk_valid === 1'b0, "R10", "still idle",
                      64'({done, lk_valid}), 64'd0);
                return;
            end
            @(negedge clk);
            req_valid = 1'b0;
        end
        check(done === 1'b1, "R11", "done pulse", 64'(done), 64'd1);
        check(busy === 1'b0 && lk_valid === 1'b0, "R11", "idle with done",
              64'({busy, lk_valid}), 64'd0);
        check(done_hit === e_hit, e_hit ? "R4" : "R5", {req, " outcome"},
              64'(done_hit), 64'(e_hit));
        check(done_target === e_tgt, e_hit ? "R4" : "R5", {req, " target"},
              64'(done_target), 64'(e_tgt));
        check(done_iter === IW'(e_iter), "R9", {req, " iteration count"},
              64'(done_iter), 64'(e_iter));
        @(negedge clk);
        check(done === 1'b0, "R11", "done one cycle", 64'(done), 64'd0);
        check(lk_valid === 1'b0, "R2", "no restart from busy request",
              64'(lk_valid), 64'd0);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && lk_valid === 1'b0 && done === 1'b0, "R1",
              "reset outputs", 64'({busy, lk_valid, done}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && lk_valid === 1'b0 && done === 1'b0, "R1",
              "after reset", 64'({busy, lk_valid, done}), 64'd0);

        // R4: taken on the first lookup
        plant(32'h0000_1000, 16'hF0F0, 1, 32'hAAAA_0001, 1);
        run_case(32'h0000_1000, 16'hF0F0, 0, 0, "R4 first");

        // R7, R8: taken on the third lookup
        plant(32'h0000_2000, 16'h1234, 1, 32'hBBBB_0001, 0);
        plant(32'h0000_2000, 16'h1234, 2, 32'hBBBB_0002, 0);
        plant(32'h0000_2000, 16'h1234, 3, 32'hBBBB_0003, 1);
        run_case(32'h0000_2000, 16'h1234, 0, 0, "R7 third");

        // Same branch, different history: history selects a different link
        plant(32'h0000_2000, 16'h5555, 2, 32'hBBBB_0002, 1);
        run_case(32'h0000_2000, 16'h5555, 0, 0, "R8 history");

        // R5: miss on the second lookup
        plant(32'h0000_3000, 16'h00FF, 1, 32'hCCCC_0001, 0);
        run_case(32'h0000_3000, 16'h00FF, 0, 0, "R5 second miss");

        // R5: miss on the first lookup
        run_case(32'h0000_5000, 16'hFFFF, 0, 0, "R5 first miss");

        // R6: all hits, none taken; a request while busy is ignored (R2)
        for (int k = 1; k <= MI; k++)
            plant(32'h0000_4000, 16'h8001, k, 32'hDDDD_0000 + k, 0);
        run_case(32'h0000_4000, 16'h8001, 0, 1, "R6 exhaust");

        // R4 at the last lookup
        for (int k = 1; k <= MI; k++)
            plant(32'h0000_6000, 16'h0F0F, k, 32'hEEEE_0000 + k, k == MI);
        run_case(32'h0000_6000, 16'h0F0F, 0, 0, "R4 last");

        // R10: flush during the second lookup
        run_case(32'h0000_4000, 16'h8001, 2, 0, "R10 flush");

        // R10: request dropped when flush is high in the same cycle
        @(negedge clk);
        req_valid = 1'b1; req_pc = 32'h0000_1000; req_ghr = 16'hF0F0; flush = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; flush = 1'b0;
        check(lk_valid === 1'b0 && busy === 1'b0, "R10", "request dropped by flush",
              64'({lk_valid, busy}), 64'd0);

        // Chain still works after the flushes
        run_case(32'h0000_1000, 16'hF0F0, 0, 0, "R4 after flush");
        finish_run();
    end

endmodule